// File: doc/BRIEF.md
# Chained Event Counter Pair

This block holds two event counters, an even-numbered one and its odd-numbered neighbour. It can join them into one wider count. Each counter is `WIDE_W` bits wide. Either counter can be loaded with a preset value. Each one advances by one step in a cycle when the global run enable and its own enable are both high and a hardware event or a software increment is present. Each counter has an overflow flag. The point where the flag is set depends on the overflow-width mode:

- In narrow mode (`wide_ovf_mode` = 0), the flag is set on a carry out of the low `NARROW_W` bits.
- In wide mode (`wide_ovf_mode` = 1), the flag is set only when the full `WIDE_W` bits wrap to zero.

The counter value always advances across all `WIDE_W` bits.

When the odd counter's event type equals the chain code (default 0x1E), it stops counting its own events. Instead it counts narrow carries out of its even partner. Each carry is held in a register for one cycle and then applied. At that moment it is gated by three conditions: the odd counter's enable, the global run enable, and narrow overflow mode. The event type is also checked when the carry is applied, so a change of type between the wrap and the apply cycle takes effect at once.

Top module: `ctr_pair_chain`

## Requirements
- R1: After reset both counters read 0, both overflow flags read 0 and no chain carry is pending.
- R2: A counter advances by exactly one in a cycle where `run_en`, its own enable, and its hardware event or software increment are all high. Both event inputs together still give one step. With `run_en` or its enable low, a counter holds its value, and software increments are ignored too.
- R3: `wr_even` / `wr_odd` load `wr_data` at the next edge and take priority over any step in that cycle. A load never sets a flag and never creates a chain carry.
- R4: `ovf_flags[0]` (even) is set at the edge where the even counter steps from a value whose low `NARROW_W` bits are all ones, when `wide_ovf_mode`=0. When `wide_ovf_mode`=1 it is set only when all `WIDE_W` bits are ones. The count is `WIDE_W` bits wide either way, so 0xFFFFFFFF steps to 0x1_0000_0000.
- R5: With `odd_evt_type`=0x1E, `en_odd`=1, `run_en`=1 and `wide_ovf_mode`=0, the odd counter rises by exactly one at the edge one cycle after the even narrow wrap. A chained odd counter ignores `odd_evt` and `sw_inc_odd`.
- R6: With `en_odd`=0 a chained odd counter does not advance on an even wrap, and the even flag is still set.
- R7: With `en_even`=0, a chained odd counter does not count even if it is enabled and events arrive.
- R8: With `wide_ovf_mode`=1 a chained odd counter never advances.
- R9: When a chained step moves the odd counter past its overflow point, `ovf_flags[1]` is set as well, giving 2'b11 for the pair.
- R10: `odd_evt_type` is checked in the apply cycle. Moving it away from 0x1E while a carry is pending drops that carry. Setting it to 0x1E chains from the next even wrap onward.
- R11: A software increment that wraps the even counter yields the same chain step as a hardware event.
- R12: `ovf_clr` clears flag bits written as one. A flag set in the same cycle stays set.
- R13: An odd counter whose type is not 0x1E counts `odd_evt` / `sw_inc_odd` like the even counter does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Global counting enable |
| en_even | input | 1 | Even counter enable |
| en_odd | input | 1 | Odd counter enable |
| wide_ovf_mode | input | 1 | 1: overflow at WIDE_W bits, no chaining; 0: overflow at NARROW_W bits |
| odd_evt_type | input | EVT_W | Odd counter event type; CHAIN_CODE selects chaining |
| even_evt | input | 1 | Hardware event for the even counter |
| odd_evt | input | 1 | Hardware event for the odd counter |
| sw_inc_even | input | 1 | Software increment, even counter |
| sw_inc_odd | input | 1 | Software increment, odd counter |
| wr_even | input | 1 | Load even counter from wr_data |
| wr_odd | input | 1 | Load odd counter from wr_data |
| wr_data | input | WIDE_W | Preset value |
| ovf_clr | input | 2 | Write-one-to-clear of the overflow flags (bit 0 even, bit 1 odd) |
| cnt_even | output | WIDE_W | Even counter value |
| cnt_odd | output | WIDE_W | Odd counter value |
| ovf_flags | output | 2 | Overflow flags, bit 0 even, bit 1 odd |

## Verification
Even counts, loads and overflow flags change at the first clock edge after the stimulus. A chained odd step lands one edge later because the carry passes through a register.

The bench drives inputs on the falling edge. It samples the even results at the next falling edge, after one rising edge. For chained cases it also checks that the odd counter has not yet moved at that point. It then checks the odd counter one falling edge later.

The retype case changes the event type inside that one-cycle window, so the check observes the apply-time gating directly.

// File: rtl/ctr_chain_pkg.sv
package ctr_chain_pkg;
  localparam int PAIR_N = 2;
  localparam int IDX_EVEN = 0;
  localparam int IDX_ODD = 1;
  localparam logic [9:0] DEF_CHAIN_CODE = 10'h01E;

  // one step request: global run, local enable, any event source
  function automatic logic step_req(input logic run, input logic en,
                                    input logic hw, input logic sw);
    return run && en && (hw || sw);
  endfunction
endpackage

// File: rtl/ctr_wrap_detect.sv
module ctr_wrap_detect #(
  parameter int NARROW_W = 32,
  parameter int WIDE_W   = 64
) (
  input  logic [WIDE_W-1:0] value,
  input  logic              wide_mode,
  output logic              narrow_full,
  output logic              ovf_point
);
  function automatic logic low_all_ones(input logic [WIDE_W-1:0] v);
    return &v[NARROW_W-1:0];
  endfunction

  always_comb begin
    narrow_full = low_all_ones(value);
    ovf_point   = wide_mode ? (&value) : narrow_full;
  end
endmodule

// File: rtl/ctr_slice.sv
module ctr_slice #(
  parameter int NARROW_W = 32,
  parameter int WIDE_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WIDE_W-1:0] load_val,
  input  logic              step,
  input  logic              wide_mode,
  output logic [WIDE_W-1:0] value,
  output logic              wrap_ev,
  output logic              narrow_carry
);
  logic narrow_full;
  logic ovf_point;
  logic real_step;

  function automatic logic [WIDE_W-1:0] next_count(input logic [WIDE_W-1:0] v);
    return v + WIDE_W'(1);
  endfunction

  ctr_wrap_detect #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) wrap_i (
    .value      (value),
    .wide_mode  (wide_mode),
    .narrow_full(narrow_full),
    .ovf_point  (ovf_point)
  );

  assign real_step    = step && !load;
  assign wrap_ev      = real_step && ovf_point;
  assign narrow_carry = real_step && narrow_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         value <= '0;
    else if (load)      value <= load_val;
    else if (real_step) value <= next_count(value);
  end
endmodule

// File: rtl/chain_carry_link.sv
module chain_carry_link #(
  parameter int             EVT_W      = 10,
  parameter logic [EVT_W-1:0] CHAIN_CODE = EVT_W'(30)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             even_carry,
  input  logic [EVT_W-1:0] odd_evt_type,
  input  logic             odd_en,
  input  logic             run_en,
  input  logic             wide_mode,
  output logic             carry_pend,
  output logic             chained,
  output logic             chain_step
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_pend <= 1'b0;
    else        carry_pend <= even_carry;
  end

  // type, enable and mode are all judged in the apply cycle
  assign chained    = (odd_evt_type == CHAIN_CODE);
  assign chain_step = carry_pend && chained && odd_en && run_en && !wide_mode;
endmodule

// File: rtl/ctr_pair_chain.sv
module ctr_pair_chain
  import ctr_chain_pkg::*;
#(
  parameter int               NARROW_W   = 32,
  parameter int               WIDE_W     = 64,
  parameter int               EVT_W      = 10,
  parameter logic [EVT_W-1:0] CHAIN_CODE = EVT_W'(DEF_CHAIN_CODE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              en_even,
  input  logic              en_odd,
  input  logic              wide_ovf_mode,
  input  logic [EVT_W-1:0]  odd_evt_type,
  input  logic              even_evt,
  input  logic              odd_evt,
  input  logic              sw_inc_even,
  input  logic              sw_inc_odd,
  input  logic              wr_even,
  input  logic              wr_odd,
  input  logic [WIDE_W-1:0] wr_data,
  input  logic [1:0]        ovf_clr,
  output logic [WIDE_W-1:0] cnt_even,
  output logic [WIDE_W-1:0] cnt_odd,
  output logic [1:0]        ovf_flags
);
  logic [PAIR_N-1:0]             step_vec;
  logic [PAIR_N-1:0]             load_vec;
  logic [PAIR_N-1:0]             wrap_vec;
  logic [PAIR_N-1:0]             ncarry_vec;
  logic [PAIR_N-1:0][WIDE_W-1:0] val_vec;
  logic                          carry_pend;
  logic                          chained;
  logic                          chain_step;

  chain_carry_link #(.EVT_W(EVT_W), .CHAIN_CODE(CHAIN_CODE)) link_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .even_carry  (ncarry_vec[IDX_EVEN]),
    .odd_evt_type(odd_evt_type),
    .odd_en      (en_odd),
    .run_en      (run_en),
    .wide_mode   (wide_ovf_mode),
    .carry_pend  (carry_pend),
    .chained     (chained),
    .chain_step  (chain_step)
  );

  always_comb begin
    step_vec[IDX_EVEN] = step_req(run_en, en_even, even_evt, sw_inc_even);
    step_vec[IDX_ODD]  = chained ? chain_step
                                 : step_req(run_en, en_odd, odd_evt, sw_inc_odd);
    load_vec = {wr_odd, wr_even};
  end

  for (genvar i = 0; i < PAIR_N; i++) begin : g_half
    logic flag_q;
    ctr_slice #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) slice_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (load_vec[i]),
      .load_val    (wr_data),
      .step        (step_vec[i]),
      .wide_mode   (wide_ovf_mode),
      .value       (val_vec[i]),
      .wrap_ev     (wrap_vec[i]),
      .narrow_carry(ncarry_vec[i])
    );
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= (flag_q && !ovf_clr[i]) || wrap_vec[i];
    end
    assign ovf_flags[i] = flag_q;
  end

  assign cnt_even = val_vec[IDX_EVEN];
  assign cnt_odd  = val_vec[IDX_ODD];

  // R4
  even_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_vec[IDX_EVEN] |=> ovf_flags[0]);
  // R9
  odd_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ncarry_vec[IDX_ODD] && !wide_ovf_mode) |=> ovf_flags[1]);
  // R5
  chain_plus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_step && !wr_odd) |=> (cnt_odd == $past(cnt_odd) + WIDE_W'(1)));
  // R8
  wide_no_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_ovf_mode && chained && !wr_odd) |=> $stable(cnt_odd));
  // R6
  odd_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_odd && !wr_odd) |=> $stable(cnt_odd));
  // R2
  run_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !wr_even) |=> $stable(cnt_even));
  // R12
  clr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr[0] && !wrap_vec[IDX_EVEN]) |=> !ovf_flags[0]);
  // R1
  pend_from_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_pend |-> $past(step_vec[IDX_EVEN]));
endmodule

// File: tb/ctr_pair_chain_tb_top.sv
module ctr_pair_chain_tb_top;
  localparam int W = 64;
  localparam logic [9:0] CHN = 10'h01E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0, en_even = 1'b0, en_odd = 1'b0, wide_ovf_mode = 1'b0;
  logic [9:0] odd_evt_type = 10'h008;
  logic even_evt = 1'b0, odd_evt = 1'b0, sw_inc_even = 1'b0, sw_inc_odd = 1'b0;
  logic wr_even = 1'b0, wr_odd = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [1:0] ovf_clr = 2'b00;
  logic [W-1:0] cnt_even, cnt_odd;
  logic [1:0] ovf_flags;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ctr_pair_chain dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .en_even(en_even), .en_odd(en_odd),
    .wide_ovf_mode(wide_ovf_mode), .odd_evt_type(odd_evt_type), .even_evt(even_evt),
    .odd_evt(odd_evt), .sw_inc_even(sw_inc_even), .sw_inc_odd(sw_inc_odd),
    .wr_even(wr_even), .wr_odd(wr_odd), .wr_data(wr_data), .ovf_clr(ovf_clr),
    .cnt_even(cnt_even), .cnt_odd(cnt_odd), .ovf_flags(ovf_flags));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // load both counters, clear flags, let any pending carry drain
  task automatic preset(input logic [W-1:0] ev, input logic [W-1:0] od);
    tick(2);
    wr_even = 1'b1; wr_data = ev; ovf_clr = 2'b11;
    tick(1);
    wr_even = 1'b0; wr_odd = 1'b1; wr_data = od;
    tick(1);
    wr_odd = 1'b0; ovf_clr = 2'b00;
    tick(1);
  endtask

  task automatic cfg(input logic run, input logic ee, input logic eo,
                     input logic wide, input logic [9:0] typ);
    run_en = run; en_even = ee; en_odd = eo; wide_ovf_mode = wide; odd_evt_type = typ;
  endtask

  task automatic pulse_even(input int n);
    even_evt = 1'b1;
    tick(n);
    even_evt = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 even", cnt_even, '0);
    chk("R1 odd", cnt_odd, '0);
    chk("R1 flags", W'(ovf_flags), '0);
  endtask

  task automatic t_basic;
    cfg(1, 1, 1, 0, 10'h008);
    preset('0, '0);
    even_evt = 1'b1; odd_evt = 1'b1; sw_inc_even = 1'b1; sw_inc_odd = 1'b1;
    tick(1);
    sw_inc_even = 1'b0; sw_inc_odd = 1'b0;
    tick(4);
    even_evt = 1'b0;
    tick(1);
    odd_evt = 1'b0;
    chk("R2 even five steps", cnt_even, 64'd5);
    chk("R13 odd own events", cnt_odd, 64'd6);
    run_en = 1'b0; even_evt = 1'b1; sw_inc_even = 1'b1;
    tick(3);
    chk("R2 run off hold", cnt_even, 64'd5);
    run_en = 1'b1; en_even = 1'b0;
    tick(2);
    even_evt = 1'b0; sw_inc_even = 1'b0;
    chk("R2 enable off hold", cnt_even, 64'd5);
  endtask

  task automatic t_load;
    cfg(1, 1, 1, 0, CHN);
    preset(64'd7, 64'd3);
    wr_even = 1'b1; wr_data = 64'hFFFF_FFFF; even_evt = 1'b1;
    tick(1);
    wr_even = 1'b0; even_evt = 1'b0;
    chk("R3 load wins", cnt_even, 64'hFFFF_FFFF);
    chk("R3 load no flag", W'(ovf_flags), '0);
    tick(2);
    chk("R3 load no carry", cnt_odd, 64'd3);
  endtask

  task automatic t_chain;
    cfg(1, 1, 1, 0, CHN);
    preset(64'hFFFF_FFF0, '0);
    odd_evt = 1'b1; sw_inc_odd = 1'b1;
    pulse_even(16);
    chk("R4 even past narrow", cnt_even, 64'h1_0000_0000);
    chk("R4 even flag", W'(ovf_flags), 64'h1);
    chk("R5 odd not yet", cnt_odd, '0);
    tick(1);
    odd_evt = 1'b0; sw_inc_odd = 1'b0;
    chk("R5 odd one later", cnt_odd, 64'd1);
  endtask

  task automatic t_odd_wrap;
    cfg(1, 1, 1, 0, CHN);
    preset(64'hFFFF_FFFF, 64'hFFFF_FFFF);
    pulse_even(1);
    tick(1);
    chk("R9 odd value", cnt_odd, 64'h1_0000_0000);
    chk("R9 pair flags", W'(ovf_flags), 64'h3);
  endtask

  task automatic t_odd_dis;
    cfg(1, 1, 0, 0, CHN);
    preset(64'hFFFF_FFFF, 64'd9);
    pulse_even(1);
    tick(1);
    chk("R6 odd held", cnt_odd, 64'd9);
    chk("R6 even flag", W'(ovf_flags), 64'h1);
  endtask

  task automatic t_even_dis;
    cfg(1, 0, 1, 0, CHN);
    preset(64'hFFFF_FFFF, 64'd4);
    odd_evt = 1'b1; sw_inc_odd = 1'b1;
    pulse_even(3);
    tick(1);
    odd_evt = 1'b0; sw_inc_odd = 1'b0;
    chk("R7 even held", cnt_even, 64'hFFFF_FFFF);
    chk("R7 odd held", cnt_odd, 64'd4);
    chk("R7 no flags", W'(ovf_flags), '0);
  endtask

  task automatic t_wide;
    cfg(1, 1, 1, 1, CHN);
    preset(64'hFFFF_FFFF, '0);
    pulse_even(1);
    tick(1);
    chk("R4 wide narrow no flag", W'(ovf_flags), '0);
    chk("R8 wide no chain", cnt_odd, '0);
    preset({W{1'b1}}, '0);
    pulse_even(1);
    chk("R4 wide wrap value", cnt_even, '0);
    chk("R4 wide wrap flag", W'(ovf_flags), 64'h1);
    tick(1);
    chk("R8 wide wrap no chain", cnt_odd, '0);
  endtask

  task automatic t_retype;
    cfg(1, 1, 1, 0, CHN);
    preset(64'hFFFF_FFFF, 64'd2);
    pulse_even(1);
    odd_evt_type = 10'h011;
    tick(1);
    chk("R10 retype drops pending", cnt_odd, 64'd2);
    odd_evt_type = CHN;
    preset(64'hFFFF_FFFF, 64'd2);
    pulse_even(1);
    tick(1);
    chk("R10 rechain counts", cnt_odd, 64'd3);
  endtask

  task automatic t_sw;
    cfg(1, 1, 1, 0, CHN);
    preset(64'hFFFF_FFFF, '0);
    sw_inc_even = 1'b1;
    tick(1);
    sw_inc_even = 1'b0;
    chk("R11 sw even wrap", cnt_even, 64'h1_0000_0000);
    tick(1);
    chk("R11 sw chain step", cnt_odd, 64'd1);
  endtask

  task automatic t_clr;
    cfg(1, 1, 1, 0, CHN);
    preset(64'hFFFF_FFFF, 64'hFFFF_FFFF);
    pulse_even(1);
    tick(1);
    ovf_clr = 2'b01;
    tick(1);
    ovf_clr = 2'b00;
    chk("R12 clear even only", W'(ovf_flags), 64'h2);
    wr_even = 1'b1; wr_data = 64'hFFFF_FFFF;
    tick(1);
    wr_even = 1'b0;
    even_evt = 1'b1; ovf_clr = 2'b01;
    tick(1);
    even_evt = 1'b0; ovf_clr = 2'b00;
    chk("R12 set beats clear", W'(ovf_flags), 64'h3);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_basic();
    t_load();
    t_chain();
    t_odd_wrap();
    t_odd_dis();
    t_even_dis();
    t_wide();
    t_retype();
    t_sw();
    t_clr();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule